// File: doc/BRIEF.md
# Double-Precision to Signed 32-Bit Integer Converter

This block takes a 64-bit IEEE-754 double-precision operand and turns it into a signed 32-bit integer. The rounding direction comes from a 2-bit mode input, and a truncate control can override it. The integer comes back inside a 64-bit register image whose upper word is a fixed tag. Alongside the image the block produces a vector of status-flag updates, a destination write enable and an exception request. A NaN or an out-of-range value does not yield a wrapped integer. It yields a saturated image and raises the invalid-conversion flags. When invalid-operation traps are enabled, the block raises an exception request and suppresses the destination write.

Operands arrive on a valid/ready input channel. Results leave on a valid/ready output channel through a single output register. An operand is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so one conversion per cycle is sustained while `out_ready` stays high. While `out_ready` is low, a pending result and all of its side outputs are held unchanged, and no new operand is accepted. The result of an accepted operand appears on the next clock edge, so `out_valid` acts as the done pulse.

Top module: `cvt_d2i`

## Requirements
- R1: The effective rounding mode is taken from `in_rmode`: 0 rounds to nearest with ties going to the even integer, 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity.
- R2: When `in_trunc` is 1, rounding is toward zero whatever `in_rmode` holds.
- R3: For an in-range result, `out_result[31:0]` holds the two's-complement integer and `out_result[63:32]` is 0xFFF80000. In that case `out_wr_en` is 1, `out_exc` is 0 and both flag vectors are zero.
- R4: On any invalid case (NaN or out of range), `out_flag_clr` is 2'b11. Its bit 1 clears fraction-rounded and its bit 0 clears fraction-inexact. In the same case `out_flag_set[1]` (invalid conversion) and `out_flag_set[2]` (invalid summary) are 1. On a valid result both vectors are zero.
- R5: A NaN whose operand bit 51 is 0 is signalling and also sets `out_flag_set[0]`. A quiet NaN leaves that bit 0.
- R6: An operand whose rounded value exceeds 2147483647 or falls below -2147483648 counts as out of range; this includes the infinities. With `in_inv_en` at 0, the image is 0xFFF800007FFFFFFF when operand bit 63 is 0 and 0xFFF8000080000000 when it is 1.
- R7: A NaN with `in_inv_en` at 0 gives the image 0xFFF8000080000000, whatever its sign.
- R8: On an invalid case with `in_inv_en` at 1, `out_flag_set[3]` (enabled-exception summary) and `out_exc` are 1 and `out_wr_en` is 0. `out_result` still shows the saturated image. In all other cases `out_flag_set[3]` and `out_exc` are 0.
- R9: The range check is applied to the rounded value. For example, 2147483647.4 rounded to nearest is valid 0x7FFFFFFF, 2147483647.5 rounded to nearest overflows, and -2147483648.9 truncated is valid 0x80000000.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output keeps its value on the next cycle.
- R11: An operand accepted on a clock edge has its result on `out_valid` and the data outputs immediately after that edge.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be accepted this cycle |
| in_operand | input | 64 | Double-precision operand bits |
| in_rmode | input | 2 | Rounding-mode field |
| in_trunc | input | 1 | Force rounding toward zero |
| in_inv_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result present (done) |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Tagged integer or saturated image |
| out_wr_en | output | 1 | Destination should be written |
| out_flag_set | output | 4 | Flags to set: [3] enabled-exception summary, [2] invalid summary, [1] invalid conversion, [0] signalling NaN |
| out_flag_clr | output | 2 | Flags to clear: [1] fraction rounded, [0] fraction inexact |
| out_exc | output | 1 | Exception request |

## Verification
The bench builds the block with its default widths: an 11-bit exponent, a 52-bit fraction and a 32-bit integer. With those widths it can feed real double values straight from behavioural reals, covering subnormals, ties on both signs, values one half-step from either limit, infinities and both kinds of NaN. A reference model built on real-number floor and ceiling predicts every output in every cycle. Random back-pressure on `out_ready` exercises the hold and refill paths at the same time.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic exc_sum;
    logic inv_sum;
    logic inv_cvt;
    logic inv_snan;
  } fset_t;

  typedef struct packed {
    logic frac_rnd;
    logic frac_inx;
  } fclr_t;

endpackage

// File: rtl/cvt_decode.sv
module cvt_decode #(
  parameter int unsigned EXW  = 11,
  parameter int unsigned FRW  = 52,
  parameter int unsigned INTW = 32
) (
  input  logic [EXW+FRW:0] op,
  output logic             sign,
  output logic             is_nan,
  output logic             is_snan,
  output logic             huge,
  output logic [INTW-1:0]  ipart,
  output logic             rbit,
  output logic             sticky
);
  localparam int unsigned GW  = FRW + 12;
  localparam int unsigned LW  = FRW + 1 + GW;
  localparam int unsigned SW  = EXW + 2;
  localparam int unsigned SHW = $clog2(LW) + 1;
  localparam logic signed [SW-1:0] BIAS  = SW'((1 << (EXW - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_E = -1;
  localparam logic signed [SW-1:0] MAX_E = SW'(INTW - 1);
  localparam logic signed [SW-1:0] FRW_S = SW'(FRW);

  logic [EXW-1:0]        expf;
  logic [FRW-1:0]        frac;
  logic                  all_ones;
  logic signed [SW-1:0]  unb;
  logic signed [SW-1:0]  sh_s;
  logic                  tiny;
  logic [LW-1:0]         wide;
  logic [LW-1:0]         shifted;

  assign expf     = op[EXW+FRW-1 -: EXW];
  assign frac     = op[FRW-1:0];
  assign sign     = op[EXW+FRW];
  assign all_ones = &expf;
  assign is_nan   = all_ones && (|frac);
  assign is_snan  = is_nan && !frac[FRW-1];
  assign unb      = $signed({2'b00, expf}) - BIAS;
  assign sh_s     = FRW_S - unb;
  assign tiny     = unb < MIN_E;
  assign huge     = all_ones || (unb > MAX_E);
  assign wide     = {1'b1, frac, {GW{1'b0}}};

  always_comb begin
    shifted = wide >> sh_s[SHW-1:0];
    ipart   = '0;
    rbit    = 1'b0;
    sticky  = 1'b0;
    if (huge) begin
      ipart = '0;
    end else if (tiny) begin
      sticky = |op[EXW+FRW-1:0];
    end else begin
      ipart  = shifted[GW +: INTW];
      rbit   = shifted[GW-1];
      sticky = |shifted[GW-2:0];
    end
  end

endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
#(
  parameter int unsigned INTW = 32
) (
  input  logic            sign,
  input  rmode_e          mode,
  input  logic [INTW-1:0] ipart,
  input  logic            rbit,
  input  logic            sticky,
  output logic [INTW:0]   mag
);
  logic inc;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = rbit && (sticky || ipart[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = !sign && (rbit || sticky);
      RM_DOWN: inc = sign && (rbit || sticky);
      default: inc = 1'b0;
    endcase
  end

  assign mag = {1'b0, ipart} + {{INTW{1'b0}}, inc};

endmodule

// File: rtl/cvt_pack.sv
module cvt_pack
  import cvt_pkg::*;
#(
  parameter int unsigned INTW = 32,
  parameter int unsigned OPW  = 64
) (
  input  logic            sign,
  input  logic            is_nan,
  input  logic            is_snan,
  input  logic            huge,
  input  logic [INTW:0]   mag,
  input  logic            inv_en,
  output logic [OPW-1:0]  result,
  output logic            wr_en,
  output fset_t           fset,
  output fclr_t           fclr,
  output logic            exc
);
  localparam int unsigned TAGW = OPW - INTW;
  localparam logic [TAGW-1:0] TAG    = {{13{1'b1}}, {(TAGW-13){1'b0}}};
  localparam logic [INTW-1:0] MAXPOS = {1'b0, {(INTW-1){1'b1}}};
  localparam logic [INTW-1:0] MINNEG = {1'b1, {(INTW-1){1'b0}}};

  logic            over;
  logic            invalid;
  logic [INTW-1:0] low;

  always_comb begin
    if (sign) over = huge || (mag > {1'b0, MINNEG});
    else      over = huge || (mag > {1'b0, MAXPOS});
  end

  assign invalid = is_nan || over;

  always_comb begin
    if (is_nan)     low = MINNEG;
    else if (over)  low = sign ? MINNEG : MAXPOS;
    else if (sign)  low = -mag[INTW-1:0];
    else            low = mag[INTW-1:0];
  end

  assign result        = {TAG, low};
  assign exc           = invalid && inv_en;
  assign wr_en         = !(invalid && inv_en);
  assign fset.exc_sum  = invalid && inv_en;
  assign fset.inv_sum  = invalid;
  assign fset.inv_cvt  = invalid;
  assign fset.inv_snan = is_snan;
  assign fclr.frac_rnd = invalid;
  assign fclr.frac_inx = invalid;

endmodule

// File: rtl/cvt_d2i.sv
module cvt_d2i
  import cvt_pkg::*;
#(
  parameter int unsigned EXW  = 11,
  parameter int unsigned FRW  = 52,
  parameter int unsigned INTW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [EXW+FRW:0]   in_operand,
  input  logic [1:0]         in_rmode,
  input  logic               in_trunc,
  input  logic               in_inv_en,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [EXW+FRW:0]   out_result,
  output logic               out_wr_en,
  output logic [3:0]         out_flag_set,
  output logic [1:0]         out_flag_clr,
  output logic               out_exc
);
  localparam int unsigned OPW = EXW + FRW + 1;

  logic            d_sign, d_nan, d_snan, d_huge, d_rbit, d_sticky;
  logic [INTW-1:0] d_ipart;
  logic [INTW:0]   r_mag;
  rmode_e          eff_mode;
  logic [OPW-1:0]  p_result;
  logic            p_wr, p_exc;
  fset_t           p_set;
  fclr_t           p_clr;
  logic            accept;

  assign eff_mode = in_trunc ? RM_ZERO : rmode_e'(in_rmode);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cvt_decode #(.EXW(EXW), .FRW(FRW), .INTW(INTW)) u_dec (
    .op(in_operand), .sign(d_sign), .is_nan(d_nan), .is_snan(d_snan),
    .huge(d_huge), .ipart(d_ipart), .rbit(d_rbit), .sticky(d_sticky)
  );

  cvt_round #(.INTW(INTW)) u_rnd (
    .sign(d_sign), .mode(eff_mode), .ipart(d_ipart), .rbit(d_rbit),
    .sticky(d_sticky), .mag(r_mag)
  );

  cvt_pack #(.INTW(INTW), .OPW(OPW)) u_pack (
    .sign(d_sign), .is_nan(d_nan), .is_snan(d_snan), .huge(d_huge),
    .mag(r_mag), .inv_en(in_inv_en), .result(p_result), .wr_en(p_wr),
    .fset(p_set), .fclr(p_clr), .exc(p_exc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_wr_en    <= 1'b0;
      out_flag_set <= '0;
      out_flag_clr <= '0;
      out_exc      <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_result   <= p_result;
      out_wr_en    <= p_wr;
      out_flag_set <= p_set;
      out_flag_clr <= p_clr;
      out_exc      <= p_exc;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_TAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_en |-> out_result[OPW-1:OPW-13] == 13'h1FFF) else $error("tag"); // R3
  AST_CLR_ONLY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (|out_flag_clr) |-> out_flag_set[1] && out_flag_set[2]) else $error("clr"); // R4
  AST_SNAN_IS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_set[0] |-> out_flag_set[1] && (&out_flag_clr)) else $error("snan"); // R5
  AST_NO_WRITE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wr_en |-> out_exc && out_flag_set[3] && out_flag_set[1]) else $error("trap"); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flag_set)
    && $stable(out_exc)) else $error("hold"); // R10
  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) else $error("done"); // R11

endmodule

// File: tb/sim_cvt_d2i.sv
module sim_cvt_d2i;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_trunc = 1'b0;
  logic        in_inv_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_flag_set;
  logic [1:0]  out_flag_clr;
  logic        out_exc;

  int checks = 0;
  int errors = 0;

  logic        m_valid = 1'b0;
  logic [63:0] m_res = '0;
  logic        m_wr = 1'b0;
  logic [3:0]  m_set = '0;
  logic [1:0]  m_clr = '0;
  logic        m_exc = 1'b0;
  string       m_tag = "R12";

  always #5 clk = ~clk;

  cvt_d2i u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_rmode(in_rmode), .in_trunc(in_trunc),
    .in_inv_en(in_inv_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_flag_set(out_flag_set),
    .out_flag_clr(out_flag_clr), .out_exc(out_exc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic ref_conv(input logic [63:0] op, input logic [1:0] rm, input logic tr,
                          input logic ie, output logic [63:0] res, output logic wr,
                          output logic [3:0] fs, output logic [1:0] fc, output logic ex);
    real v, f, d, r;
    bit nan, snan, inf, bad;
    int m;
    longint li;
    nan  = (op[62:52] == 11'h7FF) && (op[51:0] != 0);
    snan = nan && !op[51];
    inf  = (op[62:52] == 11'h7FF) && (op[51:0] == 0);
    r = 0.0;
    if (!nan && !inf) begin
      v = $bitstoreal(op);
      m = tr ? 1 : int'(rm);
      case (m)
        0: begin
          f = $floor(v); d = v - f;
          if (d > 0.5) r = f + 1.0;
          else if (d < 0.5) r = f;
          else r = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
        end
        1: r = (v < 0.0) ? $ceil(v) : $floor(v);
        2: r = $ceil(v);
        default: r = $floor(v);
      endcase
    end
    bad = nan || inf || r > 2147483647.0 || r < -2147483648.0;
    if (!bad) begin
      li  = longint'(r);
      res = {32'hFFF80000, li[31:0]};
    end else if (nan || op[63]) res = 64'hFFF8000080000000;
    else res = 64'hFFF800007FFFFFFF;
    wr = !(bad && ie);
    ex = bad && ie;
    fs = {bad && ie, bad, bad, snan};
    fc = bad ? 2'b11 : 2'b00;
  endtask

  task automatic cyc(input logic v, input logic [63:0] op, input logic [1:0] rm,
                     input logic tr, input logic ie, input logic ordy, input string req);
    logic acc;
    in_valid = v; in_operand = op; in_rmode = rm; in_trunc = tr;
    in_inv_en = ie; out_ready = ordy;
    #1;
    check(in_ready == (!m_valid || ordy), "R10", "in_ready", {63'd0, in_ready},
          {63'd0, (!m_valid || ordy)});
    acc = v && (!m_valid || ordy);
    @(posedge clk);
    if (acc) begin
      ref_conv(op, rm, tr, ie, m_res, m_wr, m_set, m_clr, m_exc);
      m_valid = 1'b1;
      m_tag = req;
    end else if (ordy) m_valid = 1'b0;
    @(negedge clk);
    check(out_valid == m_valid, "R11", "out_valid", {63'd0, out_valid}, {63'd0, m_valid});
    if (m_valid) begin
      check(out_result == m_res, m_tag, "result", out_result, m_res);
      check({out_wr_en, out_exc, out_flag_set, out_flag_clr} == {m_wr, m_exc, m_set, m_clr},
            m_tag, "side outputs", {56'd0, out_wr_en, out_exc, out_flag_set, out_flag_clr},
            {56'd0, m_wr, m_exc, m_set, m_clr});
    end
  endtask

  task automatic conv(input real x, input logic [1:0] rm, input logic tr, input string req);
    cyc(1'b1, $realtobits(x), rm, tr, 1'b0, 1'b1, req);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R12", "reset in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 each mode, ties on both signs
    conv(2.5, 2'd0, 1'b0, "R1"); conv(3.5, 2'd0, 1'b0, "R1");
    conv(-2.5, 2'd0, 1'b0, "R1"); conv(-3.5, 2'd0, 1'b0, "R1");
    conv(2.7, 2'd1, 1'b0, "R1"); conv(-2.7, 2'd1, 1'b0, "R1");
    conv(2.1, 2'd2, 1'b0, "R1"); conv(-2.1, 2'd2, 1'b0, "R1");
    conv(2.1, 2'd3, 1'b0, "R1"); conv(-2.1, 2'd3, 1'b0, "R1");
    conv(0.3, 2'd2, 1'b0, "R1"); conv(-0.3, 2'd3, 1'b0, "R1");
    conv(0.5, 2'd0, 1'b0, "R1"); conv(0.75, 2'd0, 1'b0, "R1");
    cyc(1'b1, 64'h0000000000000001, 2'd2, 1'b0, 1'b0, 1'b1, "R1");
    cyc(1'b1, 64'h8000000000000001, 2'd3, 1'b0, 1'b0, 1'b1, "R1");
    // R2 truncate override
    conv(2.7, 2'd0, 1'b1, "R2"); conv(-2.7, 2'd3, 1'b1, "R2"); conv(9.9, 2'd2, 1'b1, "R2");
    // R3 plain in-range values
    conv(0.0, 2'd0, 1'b0, "R3"); conv(-0.0, 2'd0, 1'b0, "R3");
    conv(123456789.0, 2'd0, 1'b0, "R3"); conv(-1.0, 2'd1, 1'b0, "R3");
    // R4 R5 R7 NaNs
    cyc(1'b1, 64'h7FF8000000000000, 2'd0, 1'b0, 1'b0, 1'b1, "R4");
    cyc(1'b1, 64'h7FF0000000000001, 2'd0, 1'b0, 1'b0, 1'b1, "R5");
    cyc(1'b1, 64'hFFF4000000000000, 2'd2, 1'b0, 1'b0, 1'b1, "R5");
    cyc(1'b1, 64'hFFF8000000000123, 2'd1, 1'b0, 1'b0, 1'b1, "R7");
    // R6 out of range
    conv(3.0e9, 2'd0, 1'b0, "R6"); conv(-3.0e9, 2'd0, 1'b0, "R6");
    conv(1.0e300, 2'd1, 1'b0, "R6"); conv(2147483648.0, 2'd1, 1'b0, "R6");
    cyc(1'b1, 64'h7FF0000000000000, 2'd0, 1'b0, 1'b0, 1'b1, "R6");
    cyc(1'b1, 64'hFFF0000000000000, 2'd0, 1'b0, 1'b0, 1'b1, "R6");
    // R8 traps enabled
    cyc(1'b1, $realtobits(5.0e9), 2'd0, 1'b0, 1'b1, 1'b1, "R8");
    cyc(1'b1, 64'h7FF0000000000001, 2'd0, 1'b0, 1'b1, 1'b1, "R8");
    cyc(1'b1, $realtobits(7.0), 2'd0, 1'b0, 1'b1, 1'b1, "R8");
    // R9 range after rounding
    conv(2147483647.4, 2'd0, 1'b0, "R9"); conv(2147483647.5, 2'd0, 1'b0, "R9");
    conv(2147483647.4, 2'd2, 1'b0, "R9"); conv(-2147483648.9, 2'd0, 1'b1, "R9");
    conv(-2147483648.5, 2'd0, 1'b0, "R9"); conv(-2147483648.4, 2'd3, 1'b0, "R9");
    // R10 back-pressure, then idle drain
    conv(11.0, 2'd0, 1'b0, "R10");
    cyc(1'b1, $realtobits(12.0), 2'd0, 1'b0, 1'b0, 1'b0, "R10");
    cyc(1'b1, $realtobits(13.0), 2'd0, 1'b0, 1'b0, 1'b0, "R10");
    cyc(1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b1, "R10");
    cyc(1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b1, "R11");
    // random mix with random stalls
    for (int i = 0; i < 3000; i++) begin
      real x;
      x = $itor($random) / $itor((($random & 32'h7) + 1) * 3);
      if (i % 5 == 0) x = x * 3.0;
      cyc(($random & 3) != 0, $realtobits(x), 2'($random), 1'($random),
          1'($random), ($random & 3) != 0, "R1");
    end
    cyc(1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b1, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule